// File: doc/BRIEF.md
# Policy-Driven Round-Robin Memory Slot Arbiter

Eight cores share one memory port. A free-running slot number, supplied from outside, names the core that owns the current cycle. Each core owns one cycle in turn, and the owner sequence repeats every eight cycles. The arbiter combines this owner with each core's request line and its own 6-bit slot policy, and produces at most one grant in the same cycle. A core's policy sets two things. It sets who may claim the core's own slot and in what order. It also sets which slots that belong to other cores this core may borrow.

The policy word holds a 3-bit claim code in bits [5:3] and a 3-bit partner index in bits [2:0]. Code bit 5 gives the partner first claim. Code bit 4 places a named party in second position: the partner when bit 5 is 0, and the owner when bit 5 is 1 (the second place is used only when bits 5 and 4 differ). Code bit 3 widens borrowing from "only owners that named me" to "any free slot". Each core writes its own policy through a strobe and data lane. A write lands at the clock edge and governs arbitration from the next slot on.

Top module: `shared_slot_arbiter`

## Requirements
- R1: After reset, every core's policy is code 000 with its partner field equal to its own index. A requesting owner is then granted, and an idle owner's slot goes to nobody.
- R2: At most one grant bit is high in any cycle. A grant goes only to a requesting core, and with no request there is no grant.
- R3: When bit 5 of the owner's policy is 0 and the owner requests, the owner receives its slot.
- R4: With owner code 01x and the owner idle, a requesting partner is granted ahead of every other core.
- R5: With owner code 00x and the owner idle, the partner has no precedence and the slot goes to the general pool.
- R6: With owner code 1xx, a requesting partner is granted first. Under 10x, an owner that requests is next, ahead of the pool.
- R7: Under owner code 11x, the owner has no second place. It is reached only after every other eligible core in the pool.
- R8: A core whose bit 3 is 0 may take another core's slot only if that owner's partner field (bits [2:0]) names it.
- R9: A core whose bit 3 is 1 may take any slot that its owner and the higher tiers leave free.
- R10: The pool is searched in the order owner+1, owner+2, ... modulo 8, and the owner comes last. The first eligible requester wins.
- R11: A policy write appears in arbitration only from the cycle after its strobe. Writes by several cores in one cycle all take effect.
- R12: The policy word layout is {code[2:0], partner[2:0]}, with the code in bits [5:3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 8 | Per-core access request |
| slot | input | 3 | Index of the core that owns the current cycle |
| pol_we | input | 8 | Per-core policy write strobe |
| pol_wdata | input | 48 | Policy words, core i in bits [6i+5:6i] |
| grant | output | 8 | One-hot grant for the current cycle |

## Verification
The partner's first claim under the owner's code and a borrower's own permission can both bear on the same free slot. The owner tiers and the pool search also meet when the owner is idle and several cores request at once. The bench provokes these overlaps by loading mixed policy sets and sweeping all 256 request patterns for every owner. It judges each grant against a tier-by-tier model of the requirements. A separate test puts a policy write and an arbitration in the same cycle. It expects the old policy to decide that cycle and the new one to decide the next.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
    localparam int unsigned CORE_W = 3;
    localparam int unsigned NCORES = 1 << CORE_W;
    localparam int unsigned CODE_W = 3;
    localparam int unsigned POL_W  = CODE_W + CORE_W;

    typedef logic [CORE_W-1:0] core_id_t;

    // code[2]: partner first, code[1]: named second place, code[0]: borrow any
    typedef struct packed {
        logic [CODE_W-1:0] code;
        core_id_t          partner;
    } slot_pol_t;

    typedef enum logic [1:0] {
        TIER_NONE,
        TIER_FIRST,
        TIER_SECOND,
        TIER_POOL
    } tier_e;

    typedef struct packed {
        tier_e    tier;
        core_id_t winner;
    } arb_pick_t;

    function automatic logic pol_partner_first(slot_pol_t p);
        return p.code[2];
    endfunction

    function automatic logic pol_has_second(slot_pol_t p);
        return p.code[2] ^ p.code[1];
    endfunction

    function automatic logic pol_borrow_any(slot_pol_t p);
        return p.code[0];
    endfunction

    function automatic slot_pol_t pol_reset(core_id_t self);
        slot_pol_t p;
        p.code    = '0;
        p.partner = self;
        return p;
    endfunction
endpackage

// File: rtl/ssa_policy_bank.sv
module ssa_policy_bank
    import ssa_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NCORES-1:0]       we,
    input  logic [NCORES*POL_W-1:0] wdata,
    output slot_pol_t               pol [NCORES]
);
    for (genvar i = 0; i < NCORES; i++) begin : g_core
        slot_pol_t pol_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                pol_q <= pol_reset(core_id_t'(i));
            end else if (we[i]) begin
                pol_q <= slot_pol_t'(wdata[i*POL_W +: POL_W]);
            end
        end
        assign pol[i] = pol_q;
    end
endmodule

// File: rtl/ssa_pool_pick.sv
module ssa_pool_pick
    import ssa_pkg::*;
(
    input  core_id_t          owner,
    input  core_id_t          owner_partner,
    input  logic [NCORES-1:0] req,
    input  logic [NCORES-1:0] borrow_any,
    output logic              found,
    output core_id_t          pick
);
    core_id_t id;
    logic     ok;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        id    = '0;
        ok    = 1'b0;
        // offsets 1..NCORES; the last one wraps back to the owner
        for (int k = 1; k <= NCORES; k++) begin
            id = owner + core_id_t'(k);
            ok = req[id] && ((id == owner) || borrow_any[id] || (owner_partner == id));
            if (ok && !found) begin
                found = 1'b1;
                pick  = id;
            end
        end
    end
endmodule

// File: rtl/shared_slot_arbiter.sv
module shared_slot_arbiter
    import ssa_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NCORES-1:0]       req,
    input  logic [CORE_W-1:0]       slot,
    input  logic [NCORES-1:0]       pol_we,
    input  logic [NCORES*POL_W-1:0] pol_wdata,
    output logic [NCORES-1:0]       grant
);
    slot_pol_t         pol [NCORES];
    slot_pol_t         own_pol;
    logic [NCORES-1:0] borrow_any;
    core_id_t          first_id;
    core_id_t          second_id;
    logic              pool_found;
    core_id_t          pool_id;
    arb_pick_t         pick;

    ssa_policy_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (pol_we),
        .wdata (pol_wdata),
        .pol   (pol)
    );

    for (genvar i = 0; i < NCORES; i++) begin : g_borrow
        assign borrow_any[i] = pol_borrow_any(pol[i]);
    end

    assign own_pol   = pol[slot];
    assign first_id  = pol_partner_first(own_pol) ? own_pol.partner : slot;
    assign second_id = pol_partner_first(own_pol) ? slot : own_pol.partner;

    ssa_pool_pick u_pool (
        .owner         (slot),
        .owner_partner (own_pol.partner),
        .req           (req),
        .borrow_any    (borrow_any),
        .found         (pool_found),
        .pick          (pool_id)
    );

    always_comb begin
        pick.tier   = TIER_NONE;
        pick.winner = '0;
        if (req[first_id]) begin
            pick.tier   = TIER_FIRST;
            pick.winner = first_id;
        end else if (pol_has_second(own_pol) && req[second_id]) begin
            pick.tier   = TIER_SECOND;
            pick.winner = second_id;
        end else if (pool_found) begin
            pick.tier   = TIER_POOL;
            pick.winner = pool_id;
        end
    end

    always_comb begin
        grant = '0;
        if (pick.tier != TIER_NONE) begin
            grant[pick.winner] = 1'b1;
        end
    end
endmodule

// File: rtl/ssa_checker.sv
module ssa_checker
    import ssa_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic [NCORES-1:0]       req,
    input logic [CORE_W-1:0]       slot,
    input logic [NCORES-1:0]       pol_we,
    input logic [NCORES*POL_W-1:0] pol_wdata,
    input logic [NCORES-1:0]       grant
);
    logic [POL_W-1:0] shadow [NCORES];
    logic [CODE_W-1:0] own_code;
    core_id_t          own_partner;
    logic              bad_borrow;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NCORES; i++) begin
            if (rst) begin
                shadow[i] <= {{CODE_W{1'b0}}, core_id_t'(i)};
            end else if (pol_we[i]) begin
                shadow[i] <= pol_wdata[i*POL_W +: POL_W];
            end
        end
    end

    assign own_code    = shadow[slot][POL_W-1:CORE_W];
    assign own_partner = shadow[slot][CORE_W-1:0];

    always_comb begin
        bad_borrow = 1'b0;
        for (int b = 0; b < NCORES; b++) begin
            if (grant[b] && (core_id_t'(b) != slot) &&
                !shadow[b][CORE_W] && (own_partner != core_id_t'(b))) begin
                bad_borrow = 1'b1;
            end
        end
    end

    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    a_r2_only_requesters: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

    a_r2_idle_no_grant: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |-> (grant == '0));

    a_r3_owner_first: assert property (@(posedge clk) disable iff (rst)
        (!own_code[2] && req[slot]) |-> grant[slot]);

    a_r6_partner_first: assert property (@(posedge clk) disable iff (rst)
        (own_code[2] && req[own_partner]) |-> grant[own_partner]);

    a_r8_borrow_allowed: assert property (@(posedge clk) disable iff (rst)
        !bad_borrow);
endmodule

bind shared_slot_arbiter ssa_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .slot      (slot),
    .pol_we    (pol_we),
    .pol_wdata (pol_wdata),
    .grant     (grant)
);

// File: tb/shared_slot_arbiter_tb_top.sv
module shared_slot_arbiter_tb_top;
    localparam int N = 8;
    localparam int PW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req = '0;
    logic [2:0]    slot = '0;
    logic [N-1:0]  pol_we = '0;
    logic [N*PW-1:0] pol_wdata = '0;
    logic [N-1:0]  grant;

    int tests = 0;
    int fails = 0;
    logic [5:0] sh [N];

    always #5 clk = ~clk;

    shared_slot_arbiter dut_i (
        .clk(clk), .rst(rst), .req(req), .slot(slot),
        .pol_we(pol_we), .pol_wdata(pol_wdata), .grant(grant)
    );

    // expected grant and the rule that decided it
    function automatic logic [N-1:0] model(input int o, input logic [N-1:0] r, output string tag);
        logic [2:0] c = sh[o][5:3];
        int p = int'(sh[o][2:0]);
        logic [N-1:0] g = '0;
        tag = "R2";
        if (!c[2] && r[o]) begin g[o] = 1; tag = "R3"; return g; end
        if (c[2] && r[p]) begin g[p] = 1; tag = "R6"; return g; end
        if (c == 3'b010 || c == 3'b011) begin
            if (r[p]) begin g[p] = 1; tag = "R4"; return g; end
        end
        if (c == 3'b100 || c == 3'b101) begin
            if (r[o]) begin g[o] = 1; tag = "R6"; return g; end
        end
        for (int k = 1; k <= N; k++) begin
            int id = (o + k) % N;
            if (r[id] && (id == o || sh[id][3] || p == id)) begin
                g[id] = 1; tag = "R10"; return g;
            end
        end
        return g;
    endfunction

    task automatic check(input string tag, input logic [N-1:0] exp);
        tests++;
        if (grant !== exp) begin
            fails++;
            $display("FAIL %s slot=%0d req=%b grant=%b expected=%b", tag, slot, req, grant, exp);
        end
    endtask

    task automatic drive(input int s, input logic [N-1:0] r);
        @(negedge clk);
        slot = 3'(s);
        req = r;
        #2;
    endtask

    task automatic load(input logic [5:0] v [N]);
        @(negedge clk);
        for (int i = 0; i < N; i++) pol_wdata[i*PW +: PW] = v[i];
        pol_we = '1;
        @(posedge clk);
        #1;
        pol_we = '0;
        for (int i = 0; i < N; i++) sh[i] = v[i];
    endtask

    task automatic sweep();
        string tag;
        logic [N-1:0] e;
        for (int s = 0; s < N; s++) begin
            for (int r = 0; r < 256; r++) begin
                drive(s, 8'(r));
                e = model(s, 8'(r), tag);
                check(tag, e);
            end
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [5:0] v [N];
        for (int i = 0; i < N; i++) sh[i] = {3'b000, 3'(i)};
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset policy
        drive(3, '1);          check("R1", 8'b0000_1000);
        drive(3, 8'b1111_0111); check("R1", 8'b0000_0000);
        drive(0, 8'b0000_0000); check("R2", 8'b0000_0000);

        // R11 / R12: write of {100,101} on core 2 during its own slot
        @(negedge clk);
        slot = 3'd2; req = 8'b0010_0100;
        pol_wdata = '0;
        pol_wdata[2*PW +: PW] = 6'b100_101;
        pol_we = 8'b0000_0100;
        #2 check("R11", 8'b0000_0100);
        @(posedge clk); #1 pol_we = '0; sh[2] = 6'b100_101;
        drive(2, 8'b0010_0100); check("R12", 8'b0010_0000);
        drive(2, 8'b0000_0100); check("R6", 8'b0000_0100);

        // R5: 000 owner, partner has no precedence over pool order
        for (int i = 0; i < N; i++) v[i] = {3'b000, 3'(i)};
        v[1] = 6'b000_100; v[2] = 6'b001_010;
        load(v);
        drive(1, 8'b0001_0100); check("R5", 8'b0000_0100);
        // R8: restricted borrower only via naming owner
        drive(3, 8'b0001_0000); check("R8", 8'b0000_0000);
        drive(1, 8'b0001_0000); check("R8", 8'b0001_0000);
        // R9: borrow-any core takes a free foreign slot
        drive(6, 8'b0000_0100); check("R9", 8'b0000_0100);

        // R7: 110 owner goes after pool members
        v[6] = 6'b110_000; v[7] = 6'b001_111;
        load(v);
        drive(6, 8'b1100_0000); check("R7", 8'b1000_0000);
        drive(6, 8'b0100_0000); check("R7", 8'b0100_0000);
        drive(6, 8'b0100_0001); check("R7", 8'b0000_0001);

        // uniform code sweeps
        for (int c = 0; c < 8; c++) begin
            for (int i = 0; i < N; i++) v[i] = {3'(c), 3'((i + 3) % N)};
            load(v);
            sweep();
        end
        // mixed policy sweeps
        for (int m = 0; m < 8; m++) begin
            for (int i = 0; i < N; i++) v[i] = {3'((i * 3 + m) % 8), 3'((i * 5 + m) % N)};
            load(v);
            sweep();
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule